// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable single-clock static memory with a registered read path and a delayed write data phase. Each rising edge captures an address, a chip select, a write strobe and one active-low enable per 9-bit byte lane. For a write, the data word is sampled one edge later. For a read, the word appears at a registered output one edge after capture. The default geometry is 1024 words of four 9-bit lanes.

Write data always lags its address by one cycle. A buffer therefore holds the newest write (address, lane mask, data) until a non-read cycle commits it to the array. Reads that hit the buffered address get the buffered lanes merged in, so a read always returns the result of every write issued before it. The output driver turns off only after two consecutive deselect cycles. Output enable gates the valid and drive indications asynchronously. A sleep input blocks new operations while keeping the stored contents.

Top module: `latewrite_sram`

## Requirements
- R1: After reset, `q_vld` and `q_drive` are low and no write is pending.
- R2: A read (`cs_n`=0, `wr_n`=1) captured on edge N puts the word on `q` and raises `q_vld` after edge N+1. `q_vld` stays high for exactly one cycle per read.
- R3: A write (`cs_n`=0, `wr_n`=0) captured on edge N takes `wdata` on edge N+1. Lane k occupies bits 9k+8..9k and is written only if `lane_en_n[k]`=0. Any set of lanes may be written.
- R4: A write with every `lane_en_n` bit high is an abort and changes no stored bit.
- R5: A read returns the merged result of all earlier writes. This includes a write whose data arrives on the read's own capture edge and is still held in the pending buffer.
- R6: Writes issued on consecutive cycles are all accepted without stalling, and every one reaches the array.
- R7: `q_drive` rises with read data. A single deselect cycle (`cs_n`=1) does not turn it off. With two consecutive deselect cycles, it falls on the edge after the second one is captured.
- R8: A write cycle turns `q_drive` off on the edge after the write is captured, leaving the bus free for the data phase.
- R9: While `oe_n` is high, `q_vld` and `q_drive` are low, with no clock edge needed. Lowering `oe_n` restores the registered state.
- R10: While `sleep` is high, a captured cycle acts as a deselect: no read or write is started and stored data is kept. Data for a write captured before sleep rose is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; high means read |
| addr | input | AW (10) | Word address |
| lane_en_n | input | LANES (4) | Per-lane write enables, active low |
| wdata | input | LANES*LW (36) | Write data, one edge after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Blocks new operations, keeps contents |
| q | output | LANES*LW (36) | Registered read data |
| q_vld | output | 1 | Read data valid, gated by `oe_n` |
| q_drive | output | 1 | Output driver on, gated by `oe_n` |

## Verification
A scoreboard model predicts every read word from the writes issued before it. The read patterns are:
- full-word fills followed by readback;
- sparse lane masks;
- an all-disabled mask;
- a read placed right behind a write to the same address;
- a write immediately overwritten in the buffer by another write.

The fill-and-readback case shows that plain storage and back-to-back writes work. The other patterns separate a correct lane merge from whole-word writes, from a broken bypass and from an abort that writes anyway. The drive tests split a single deselect from a double deselect and from a write turnaround. The sleep test shows that a read or write captured under sleep has no effect, while late data for an earlier write still lands.

// File: rtl/lws_pkg.sv
package lws_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_t;
endpackage

// File: rtl/lws_front.sv
module lws_front
  import lws_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   wr_n,
  input  logic                   sleep,
  input  logic [AW-1:0]          addr,
  input  logic [LANES-1:0]       lane_en_n,
  input  logic [LANES*LW-1:0]    wdata,
  output op_t                    s1_op,
  output logic [AW-1:0]          s1_addr,
  output logic                   pend_v,
  output logic [AW-1:0]          pend_addr,
  output logic [LANES-1:0]       pend_mask,
  output logic [LANES*LW-1:0]    pend_data,
  output logic                   cmt_en
);
  localparam int DW = LANES * LW;

  logic [LANES-1:0] s1_mask;

  // capture stage plus late-write buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op     <= OP_NOP;
      s1_addr   <= '0;
      s1_mask   <= '0;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_mask <= '0;
      pend_data <= '0;
    end else begin
      if (sleep || cs_n)
        s1_op <= OP_NOP;
      else if (wr_n)
        s1_op <= OP_RD;
      else
        s1_op <= OP_WR;
      s1_addr <= addr;
      s1_mask <= ~lane_en_n;
      if (s1_op == OP_WR) begin
        pend_v    <= 1'b1;
        pend_addr <= s1_addr;
        pend_mask <= s1_mask;
        pend_data <= wdata[DW-1:0];
      end else if (s1_op == OP_NOP) begin
        pend_v <= 1'b0;
      end
    end
  end

  // array port is free on every non-read cycle
  assign cmt_en = pend_v && (s1_op != OP_RD);
endmodule

// File: rtl/lws_array.sv
module lws_array #(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmt_en,
  input  logic [AW-1:0]       cmt_addr,
  input  logic [LANES-1:0]    cmt_mask,
  input  logic [LANES*LW-1:0] cmt_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  input  logic                byp_v,
  output logic [LANES*LW-1:0] q_r
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word;
  logic [DW-1:0] merged;
  logic          hit;

  // single port: commit writes on non-read cycles only
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (cmt_en && cmt_mask[k])
        mem[cmt_addr][k*LW +: LW] <= cmt_data[k*LW +: LW];
    end
  end

  assign rd_word = mem[rd_addr];
  assign hit     = byp_v && (cmt_addr == rd_addr);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LW +: LW] = (hit && cmt_mask[g]) ? cmt_data[g*LW +: LW]
                                                        : rd_word[g*LW +: LW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      q_r <= '0;
    else if (rd_en)
      q_r <= merged;
  end
endmodule

// File: rtl/lws_outctl.sv
module lws_outctl
  import lws_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_t  s1_op,
  output logic vld_r,
  output logic drv_r,
  output logic ds2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_r <= 1'b0;
      drv_r <= 1'b0;
      ds2   <= 1'b0;
    end else begin
      vld_r <= (s1_op == OP_RD);
      ds2   <= (s1_op == OP_NOP);
      case (s1_op)
        OP_RD:   drv_r <= 1'b1;
        OP_WR:   drv_r <= 1'b0;
        default: if (ds2) drv_r <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lws_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    lane_en_n,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                oe_n,
  input  logic                sleep,
  output logic [LANES*LW-1:0] q,
  output logic                q_vld,
  output logic                q_drive
);
  localparam int DW = LANES * LW;

  op_t              s1_op;
  logic [AW-1:0]    s1_addr;
  logic             pend_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_mask;
  logic [DW-1:0]    pend_data;
  logic             cmt_en;
  logic [DW-1:0]    q_r;
  logic             vld_r;
  logic             drv_r;
  logic             ds2;

  lws_front #(.AW(AW), .LANES(LANES), .LW(LW)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .sleep(sleep),
    .addr(addr), .lane_en_n(lane_en_n), .wdata(wdata),
    .s1_op(s1_op), .s1_addr(s1_addr), .pend_v(pend_v),
    .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data),
    .cmt_en(cmt_en)
  );

  lws_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .rst(rst), .cmt_en(cmt_en), .cmt_addr(pend_addr),
    .cmt_mask(pend_mask), .cmt_data(pend_data),
    .rd_en(s1_op == OP_RD), .rd_addr(s1_addr), .byp_v(pend_v), .q_r(q_r)
  );

  lws_outctl u_outctl (
    .clk(clk), .rst(rst), .s1_op(s1_op),
    .vld_r(vld_r), .drv_r(drv_r), .ds2(ds2)
  );

  assign q       = q_r;
  assign q_vld   = vld_r & ~oe_n;
  assign q_drive = drv_r & ~oe_n;
endmodule

// File: rtl/lws_sva.sv
module lws_sva
  import lws_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic sleep,
  input op_t  s1_op,
  input logic ds2,
  input logic drv,
  input logic vld,
  input logic pend_v
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_RD) |=> vld); // R2
  AST_VLD_ONLY_FROM_RD: assert property (@(posedge clk) disable iff (rst)
    (s1_op != OP_RD) |=> !vld); // R2
  AST_WR_BUFFERED: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_WR) |=> pend_v); // R6
  AST_RD_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_RD && pend_v) |=> pend_v); // R5
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (s1_op == OP_NOP)); // R10
  AST_DCD_OFF: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_NOP && ds2) |=> !drv); // R7
  AST_DCD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_NOP && !ds2) |=> $stable(drv)); // R7
  AST_WR_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_WR) |=> !drv); // R8
endmodule

bind latewrite_sram lws_sva u_sva (
  .clk(clk), .rst(rst), .sleep(sleep), .s1_op(s1_op),
  .ds2(ds2), .drv(drv_r), .vld(vld_r), .pend_v(pend_v)
);

// File: tb/latewrite_sram_tb.sv
module latewrite_sram_tb;
  localparam int AW    = 10;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cs_n = 1'b1;
  logic             wr_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] lane_en_n = '1;
  logic [DW-1:0]    wdata = '0;
  logic             oe_n = 1'b0;
  logic             sleep = 1'b0;
  logic [DW-1:0]    q;
  logic             q_vld;
  logic             q_drive;

  always #10 clk = ~clk;

  latewrite_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .lane_en_n(lane_en_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .q(q), .q_vld(q_vld), .q_drive(q_drive)
  );

  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;
  logic [DW-1:0] model [0:(1<<AW)-1];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic [DW-1:0] held_wd = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: sets one cycle of inputs, updates the model, queues expected reads
  task automatic step(input logic s_n, input logic w_n, input logic [AW-1:0] a,
                      input logic [LANES-1:0] b, input logic [DW-1:0] d, input string tag);
    cs_n = s_n; wr_n = w_n; addr = a; lane_en_n = b;
    wdata = held_wd;
    held_wd = d;
    if (!sleep && !s_n) begin
      if (w_n) begin
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
      end else begin
        for (int l = 0; l < LANES; l++)
          if (!b[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
      end
    end
    @(negedge clk);
  endtask

  task automatic nop();
    step(1'b1, 1'b1, '0, '1, '0, "");
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b1, a, '1, '0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] b, input logic [DW-1:0] d);
    step(1'b0, 1'b0, a, b, d, "");
  endtask

  // monitor: pops the scoreboard whenever read data is flagged valid
  always @(negedge clk) begin
    if (!rst && q_vld) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected q_vld actual=%h expected=none", q);
      end else begin
        chk(tag_q.pop_front(), q, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 q_vld", DW'(q_vld), '0);
    chk("R1 q_drive", DW'(q_drive), '0);

    // R6: back-to-back full writes, then readback
    for (int i = 0; i < 8; i++) wr(AW'(i), 4'b0000, DW'(36'h1_0203_0405) * DW'(i + 3));
    nop();
    for (int i = 0; i < 8; i++) rd(AW'(i), "R6");
    nop(); nop();

    // R3: sparse lane mask
    wr(2, 4'b1010, 36'h1FF_0AA_155);
    nop(); nop();
    rd(2, "R3");
    wr(1, 4'b0101, 36'hABC_DEF_123);
    nop();
    rd(1, "R3");
    nop(); nop();

    // R4: abort
    wr(3, 4'b1111, 36'hFFF_FFF_FFF);
    nop(); nop();
    rd(3, "R4");
    nop(); nop();

    // R5: read right behind writes, buffer overwritten
    wr(4, 4'b0110, 36'h123_456_789);
    rd(4, "R5");
    wr(4, 4'b1001, 36'h987_654_321);
    wr(5, 4'b0000, 36'h0F0_F0F_0F0);
    rd(4, "R5");
    rd(5, "R5");
    nop(); nop(); nop();

    // R2: exact latency and single-cycle valid
    rd(6, "R2");
    chk("R2 before N+1", DW'(q_vld), '0);
    nop();
    chk("R2 after N+1", DW'(q_vld), 1);
    nop();
    chk("R2 one cycle", DW'(q_vld), '0);
    nop(); nop();

    // R7: double deselect turns drive off
    rd(7, "R7");
    nop();
    chk("R7 drive on", DW'(q_drive), 1);
    nop();
    chk("R7 first deselect", DW'(q_drive), 1);
    nop();
    chk("R7 second deselect", DW'(q_drive), '0);

    // R7: single deselect keeps drive
    rd(0, "R7");
    nop();
    chk("R7 single a", DW'(q_drive), 1);
    rd(1, "R7");
    chk("R7 single b", DW'(q_drive), 1);
    nop();
    chk("R7 single c", DW'(q_drive), 1);

    // R8: write turnaround
    wr(0, 4'b0000, 36'h055_5AA_A55);
    chk("R8 before", DW'(q_drive), 1);
    nop();
    chk("R8 after write", DW'(q_drive), '0);
    nop(); nop();

    // R9: asynchronous output enable
    rd(0, "R9");
    nop();
    #5 oe_n = 1'b1;
    #1;
    chk("R9 q_vld gated", DW'(q_vld), '0);
    chk("R9 q_drive gated", DW'(q_drive), '0);
    oe_n = 1'b0;
    #1;
    chk("R9 q_vld back", DW'(q_vld), 1);
    chk("R9 q_drive back", DW'(q_drive), 1);
    nop(); nop(); nop();

    // R10: sleep blocks operations, late data still lands
    sleep = 1'b1;
    wr(5, 4'b0000, 36'h111_111_111);
    chk("R10 sleep a", DW'(q_vld), '0);
    rd(5, "R10");
    chk("R10 sleep b", DW'(q_vld), '0);
    nop();
    chk("R10 sleep c", DW'(q_vld), '0);
    sleep = 1'b0;
    wr(6, 4'b0000, 36'h2A2_A2A_2A2);
    sleep = 1'b1;
    nop();
    nop();
    sleep = 1'b0;
    rd(5, "R10");
    rd(6, "R10");
    nop(); nop(); nop(); nop();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule